// File: doc/BRIEF.md
# Bidirectional AES-128 Round-Key Walker

This block keeps a single 128-bit AES-128 round key in a working register. On command it replaces that key with the next round key or with the previous one. It does not store all eleven round keys. A round datapath asks it for one key per round, in ascending order for encryption and in descending order for decryption. The byte substitution needed for each step is borrowed from an S-box shared with the datapath. The walker sends one 32-bit word out in a single-cycle request and waits until the substituted word comes back with an acknowledge.

A cipher key load writes the key into the working register and also into a separate holding register. A setup command walks forward on its own until it reaches round key 10, which is where decryption starts. Single forward and backward step commands move one round at a time, and the round index saturates at both ends. A restore command copies the holding register back into the working register in one cycle. The next block can therefore start from round key 0 without a 20-cycle backward walk. Word 0 of a key is bits 127:96 and word 3 is bits 31:0.

Top module: `aes128_rkey_walker`

## Requirements
- R1: After reset the round index is 0, the working key is all zeros, key_valid is 1 and sbox_req is 0.
- R2: A key load accepted while idle sets the working key to key_in and the round index to 0 in the next cycle, and it stores key_in for later restore.
- R3: A forward step from round r computes round key r+1 with the AES-128 recurrence. The new word 0 is word 0 XOR the substituted, rotated word 3 XOR {rcon(r+1), 24'h0}, where rcon(i) = x^(i-1) over GF(2^8) with polynomial 0x11B. Each later word is the old word XOR the new word before it.
- R4: A backward step from round r recovers round key r-1. Words 3 to 1 are the XOR of each word with its left neighbour. Word 0 is old word 0 XOR the substituted, rotated recovered word 3 XOR {rcon(r), 24'h0}.
- R5: A step raises sbox_req for exactly one cycle, in the cycle after the command. The key and round index then hold until sbox_ack is sampled high. With an acknowledge one cycle after the request, a step takes 2 cycles; each extra cycle of S-box delay adds one cycle.
- R6: While sbox_req is high, sbox_word carries {w3[23:0], w3[31:24]} for a forward step. For a backward step it carries the same rotation of (w3 XOR w2).
- R7: The round index never exceeds 10. A forward step or setup at round 10, and a backward step at round 0, are ignored: no request is made and the key is unchanged.
- R8: A setup command walks forward without further commands until round 10 is reached. With an immediate S-box this takes 2 cycles per remaining round, which is 20 cycles from round 0.
- R9: A restore accepted while idle sets the round index to 0 and the working key to the last loaded cipher key in the next cycle, from any round.
- R10: Commands are taken only while idle, in the priority load, restore, setup, forward step, backward step. Commands that arrive during a step are ignored.
- R11: key_valid is 1 exactly when no step is in progress, and it is never 1 while sbox_req is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_in | input | 128 | Cipher key for a load |
| key_load | input | 1 | Load key_in as round key 0 and keep a copy of it |
| key_restore | input | 1 | Return to the kept cipher key in one cycle |
| key_setup | input | 1 | Walk forward to round key 10 |
| step_fwd | input | 1 | Advance one round |
| step_bwd | input | 1 | Go back one round |
| sbox_req | output | 1 | One-cycle substitution request |
| sbox_word | output | 32 | Word to substitute, valid with sbox_req |
| sbox_ack | input | 1 | Substituted word is present |
| sbox_sub | input | 32 | Substituted word, valid with sbox_ack |
| round_key | output | 128 | Current round key |
| round_idx | output | 4 | Index of the current round key, 0 to 10 |
| key_valid | output | 1 | Idle; round_key and round_idx are stable |

## Verification
The embedded properties check on every cycle that a request is a single pulse, that the key and index stay frozen while an acknowledge is pending, and that the index moves by exactly one per completed step in the stored direction. They also check that the index stays within range, that steps at a limit leave the key alone, and that load and restore land on round 0 with the right key. The values of the keys themselves, the arithmetic of both recurrences, the S-box word presented, the length of a setup walk and the effect of a slow S-box can only be shown by the bench. The bench compares every cycle against its own word-array key expansion and against known AES-128 round keys.

// File: rtl/ks_pkg.sv
package ks_pkg;
  localparam int KEY_W  = 128;
  localparam int WORD_W = 32;
  localparam int RND_W  = 4;
  localparam int ROUNDS = 10;
  localparam logic [RND_W-1:0] LAST_RND = RND_W'(ROUNDS);
  localparam logic [RND_W-1:0] RND_ONE  = RND_W'(1);

  typedef enum logic [1:0] {KS_IDLE, KS_ISSUE, KS_WAIT} ks_state_e;

  // multiply by x modulo the AES field polynomial
  function automatic logic [7:0] ks_xtime(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  // round constant for round r (1..10): x^(r-1)
  function automatic logic [7:0] ks_rcon(input logic [RND_W-1:0] r);
    logic [7:0] rc;
    rc = 8'h01;
    for (int i = 1; i < ROUNDS; i++)
      if (RND_W'(i) < r) rc = ks_xtime(rc);
    return rc;
  endfunction

  function automatic logic [WORD_W-1:0] ks_rot(input logic [WORD_W-1:0] w);
    return {w[23:0], w[31:24]};
  endfunction

  // word presented to the S-box for each direction
  function automatic logic [WORD_W-1:0] ks_sbox_in(input logic [KEY_W-1:0] k, input logic fwd);
    return fwd ? ks_rot(k[31:0]) : ks_rot(k[31:0] ^ k[63:32]);
  endfunction

  function automatic logic [KEY_W-1:0] ks_fwd(input logic [KEY_W-1:0] k,
                                              input logic [WORD_W-1:0] sub,
                                              input logic [7:0] rc);
    logic [WORD_W-1:0] a, b, c, d;
    a = k[127:96] ^ sub ^ {rc, 24'h0};
    b = k[95:64] ^ a;
    c = k[63:32] ^ b;
    d = k[31:0]  ^ c;
    return {a, b, c, d};
  endfunction

  function automatic logic [KEY_W-1:0] ks_bwd(input logic [KEY_W-1:0] k,
                                              input logic [WORD_W-1:0] sub,
                                              input logic [7:0] rc);
    logic [WORD_W-1:0] a, b, c, d;
    d = k[31:0]  ^ k[63:32];
    c = k[63:32] ^ k[95:64];
    b = k[95:64] ^ k[127:96];
    a = k[127:96] ^ sub ^ {rc, 24'h0};
    return {a, b, c, d};
  endfunction
endpackage

// File: rtl/ks_step.sv
module ks_step
  import ks_pkg::*;
(
  input  logic [KEY_W-1:0]  cur_key,
  input  logic              dir_fwd,
  input  logic [RND_W-1:0]  cur_round,
  input  logic [WORD_W-1:0] sub_word,
  output logic [WORD_W-1:0] sbox_in,
  output logic [KEY_W-1:0]  key_nxt
);
  logic [7:0] rc;

  assign sbox_in = ks_sbox_in(cur_key, dir_fwd);
  assign rc      = dir_fwd ? ks_rcon(cur_round + RND_ONE) : ks_rcon(cur_round);
  assign key_nxt = dir_fwd ? ks_fwd(cur_key, sub_word, rc) : ks_bwd(cur_key, sub_word, rc);
endmodule

// File: rtl/ks_key_cache.sv
module ks_key_cache
  import ks_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [KEY_W-1:0] wr_key,
  output logic [KEY_W-1:0] held_key
);
  always_ff @(posedge clk) begin
    if (!rst_n)     held_key <= '0;
    else if (wr_en) held_key <= wr_key;
  end
endmodule

// File: rtl/ks_ctrl.sv
module ks_ctrl
  import ks_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_load,
  input  logic             cmd_restore,
  input  logic             cmd_setup,
  input  logic             cmd_fwd,
  input  logic             cmd_bwd,
  input  logic             sbox_ack,
  output logic [RND_W-1:0] round_q,
  output logic             dir_fwd_q,
  output logic             st_issue,
  output logic             st_idle,
  output logic             step_done,
  output logic             load_evt,
  output logic             restore_evt
);
  ks_state_e st_q, st_d;
  logic auto_q;
  logic setup_sel, fwd_sel, bwd_sel, start_fwd, start_bwd;

  assign st_idle     = (st_q == KS_IDLE);
  assign st_issue    = (st_q == KS_ISSUE);
  assign step_done   = (st_q == KS_WAIT) && sbox_ack;

  assign load_evt    = st_idle && cmd_load;
  assign restore_evt = st_idle && !cmd_load && cmd_restore;
  assign setup_sel   = st_idle && !cmd_load && !cmd_restore && cmd_setup;
  assign fwd_sel     = st_idle && !cmd_load && !cmd_restore && !cmd_setup && cmd_fwd;
  assign bwd_sel     = st_idle && !cmd_load && !cmd_restore && !cmd_setup && !cmd_fwd && cmd_bwd;
  assign start_fwd   = (setup_sel || fwd_sel) && (round_q != LAST_RND);
  assign start_bwd   = bwd_sel && (round_q != '0);

  always_comb begin
    st_d = st_q;
    case (st_q)
      KS_IDLE:  if (start_fwd || start_bwd) st_d = KS_ISSUE;
      KS_ISSUE: st_d = KS_WAIT;
      KS_WAIT:  if (sbox_ack)
                  st_d = (auto_q && dir_fwd_q && (round_q != LAST_RND - RND_ONE)) ? KS_ISSUE : KS_IDLE;
      default:  st_d = KS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= KS_IDLE;
      round_q   <= '0;
      dir_fwd_q <= 1'b1;
      auto_q    <= 1'b0;
    end else begin
      st_q <= st_d;
      if (load_evt || restore_evt) round_q <= '0;
      else if (step_done)          round_q <= dir_fwd_q ? round_q + RND_ONE : round_q - RND_ONE;
      if (start_fwd || start_bwd) begin
        dir_fwd_q <= start_fwd;
        auto_q    <= setup_sel;
      end
    end
  end

  // R5
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_issue |=> !st_issue);
  // R3
  fwd_delta_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_done && dir_fwd_q) |=> round_q == $past(round_q) + RND_ONE);
  // R4
  bwd_delta_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_done && !dir_fwd_q) |=> round_q == $past(round_q) - RND_ONE);
  // R7
  round_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    round_q <= LAST_RND);
endmodule

// File: rtl/aes128_rkey_walker.sv
module aes128_rkey_walker
  import ks_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [KEY_W-1:0]  key_in,
  input  logic              key_load,
  input  logic              key_restore,
  input  logic              key_setup,
  input  logic              step_fwd,
  input  logic              step_bwd,
  output logic              sbox_req,
  output logic [WORD_W-1:0] sbox_word,
  input  logic              sbox_ack,
  input  logic [WORD_W-1:0] sbox_sub,
  output logic [KEY_W-1:0]  round_key,
  output logic [RND_W-1:0]  round_idx,
  output logic              key_valid
);
  logic [KEY_W-1:0] key_q, key_nxt, cache_key;
  logic dir_fwd, st_issue, st_idle, step_done, load_evt, restore_evt;

  ks_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_load(key_load), .cmd_restore(key_restore), .cmd_setup(key_setup),
    .cmd_fwd(step_fwd), .cmd_bwd(step_bwd), .sbox_ack(sbox_ack),
    .round_q(round_idx), .dir_fwd_q(dir_fwd), .st_issue(st_issue), .st_idle(st_idle),
    .step_done(step_done), .load_evt(load_evt), .restore_evt(restore_evt)
  );

  ks_step u_step (
    .cur_key(key_q), .dir_fwd(dir_fwd), .cur_round(round_idx),
    .sub_word(sbox_sub), .sbox_in(sbox_word), .key_nxt(key_nxt)
  );

  ks_key_cache u_cache (
    .clk(clk), .rst_n(rst_n), .wr_en(load_evt), .wr_key(key_in), .held_key(cache_key)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)           key_q <= '0;
    else if (load_evt)    key_q <= key_in;
    else if (restore_evt) key_q <= cache_key;
    else if (step_done)   key_q <= key_nxt;
  end

  assign round_key = key_q;
  assign sbox_req  = st_issue;
  assign key_valid = st_idle;

  // R2
  load_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && key_load) |=> (round_key == $past(key_in)) && (round_idx == '0));
  // R9
  restore_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && key_restore && !key_load) |=> (round_idx == '0) && (round_key == cache_key));
  // R5
  hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!key_valid && !sbox_ack) |=> $stable(round_key) && $stable(round_idx));
  // R7
  fwd_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && (step_fwd || key_setup) && !key_load && !key_restore && round_idx == LAST_RND)
      |=> key_valid && $stable(round_key) && !sbox_req);
  // R7
  bwd_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && step_bwd && !step_fwd && !key_setup && !key_load && !key_restore && round_idx == '0)
      |=> key_valid && $stable(round_key) && !sbox_req);
  // R11
  valid_vs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sbox_req |-> !key_valid);
endmodule

// File: tb/aes128_rkey_walker_test.sv
module aes128_rkey_walker_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [127:0] key_in = '0;
  logic key_load = 0, key_restore = 0, key_setup = 0, step_fwd = 0, step_bwd = 0;
  logic sbox_req, sbox_ack;
  logic [31:0] sbox_word, sbox_sub;
  logic [127:0] round_key;
  logic [3:0] round_idx;
  logic key_valid;

  always #5 clk = ~clk;

  aes128_rkey_walker uut (
    .clk(clk), .rst_n(rst_n), .key_in(key_in), .key_load(key_load),
    .key_restore(key_restore), .key_setup(key_setup), .step_fwd(step_fwd),
    .step_bwd(step_bwd), .sbox_req(sbox_req), .sbox_word(sbox_word),
    .sbox_ack(sbox_ack), .sbox_sub(sbox_sub), .round_key(round_key),
    .round_idx(round_idx), .key_valid(key_valid)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  string cur_tag = "R1";

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // ---- reference S-box built from field arithmetic ----
  logic [7:0] sb_tab [0:255];
  function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 0, x = a, y = b;
    for (int i = 0; i < 8; i++) begin
      if (y[0]) p ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
      y = y >> 1;
    end
    return p;
  endfunction
  function automatic logic [7:0] rl(input logic [7:0] b, input int n);
    return (b << n) | (b >> (8 - n));
  endfunction
  initial begin
    for (int v = 0; v < 256; v++) begin
      logic [7:0] inv = 0;
      for (int u = 1; u < 256; u++) if (gm(8'(v), 8'(u)) == 8'h01) inv = 8'(u);
      sb_tab[v] = inv ^ rl(inv, 1) ^ rl(inv, 2) ^ rl(inv, 3) ^ rl(inv, 4) ^ 8'h63;
    end
  end
  function automatic logic [31:0] sub_w(input logic [31:0] w);
    return {sb_tab[w[31:24]], sb_tab[w[23:16]], sb_tab[w[15:8]], sb_tab[w[7:0]]};
  endfunction

  // ---- word-array expansion used as the reference ----
  logic [31:0] bw [0:43];
  task automatic expand(input logic [127:0] k);
    logic [31:0] t;
    logic [7:0] rc = 8'h01;
    for (int i = 0; i < 4; i++) bw[i] = k[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = bw[i-1];
      if (i % 4 == 0) begin
        t = sub_w({t[23:0], t[31:24]}) ^ {rc, 24'h0};
        rc = gm(rc, 8'h02);
      end
      bw[i] = bw[i-4] ^ t;
    end
  endtask
  function automatic logic [127:0] exp_key(input int r);
    return {bw[4*r], bw[4*r+1], bw[4*r+2], bw[4*r+3]};
  endfunction

  // ---- S-box model with adjustable delay after the pipeline stage ----
  int sb_lat = 0, sb_cnt = 0;
  bit sb_pend = 0;
  logic [31:0] sb_w = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      sbox_ack <= 0; sbox_sub <= 0; sb_pend = 0;
    end else begin
      sbox_ack <= 0;
      if (sbox_req) begin sb_pend = 1; sb_cnt = sb_lat; sb_w = sbox_word; end
      if (sb_pend) begin
        if (sb_cnt == 0) begin sbox_ack <= 1; sbox_sub <= sub_w(sb_w); sb_pend = 0; end
        else sb_cnt--;
      end
    end
  end

  // ---- cycle model: 0 idle, 1 issue, 2 wait ----
  int m_st = 0, m_round = 0;
  bit m_dir = 1, m_auto = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_round = 0; expand('0);
    end else begin
      case (m_st)
        0: if (key_load) begin expand(key_in); m_round = 0; end
           else if (key_restore) m_round = 0;
           else if (key_setup) begin
             if (m_round != 10) begin m_dir = 1; m_auto = 1; m_st = 1; end
           end else if (step_fwd) begin
             if (m_round != 10) begin m_dir = 1; m_auto = 0; m_st = 1; end
           end else if (step_bwd) begin
             if (m_round != 0) begin m_dir = 0; m_auto = 0; m_st = 1; end
           end
        1: m_st = 2;
        default: if (sbox_ack) begin
             m_round = m_dir ? m_round + 1 : m_round - 1;
             m_st = (m_auto && m_round != 10) ? 1 : 0;
           end
      endcase
    end
  end

  // ---- per-cycle comparison ----
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(round_key == exp_key(m_round), {cur_tag, " round_key"}, round_key, exp_key(m_round));
      chk(round_idx == 4'(m_round), {cur_tag, " round_idx"}, 128'(round_idx), 128'(m_round));
      chk(key_valid == (m_st == 0), "R11 key_valid", 128'(key_valid), 128'(m_st == 0));
      chk(sbox_req == (m_st == 1), "R5 sbox_req", 128'(sbox_req), 128'(m_st == 1));
      if (m_st == 1) begin
        logic [31:0] ew;
        ew = m_dir ? bw[4*m_round+3] : bw[4*m_round-1];
        ew = {ew[23:0], ew[31:24]};
        chk(sbox_word == ew, "R6 sbox_word", 128'(sbox_word), 128'(ew));
      end
    end
  end

  // ---- stimulus ----
  task automatic cmd(input int which);
    @(negedge clk);
    case (which)
      0: key_load = 1;
      1: key_restore = 1;
      2: key_setup = 1;
      3: step_fwd = 1;
      default: step_bwd = 1;
    endcase
    @(negedge clk);
    key_load = 0; key_restore = 0; key_setup = 0; step_fwd = 0; step_bwd = 0;
  endtask
  task automatic wait_idle(output int n);
    n = 0;
    while (!key_valid && n < 1000) begin @(negedge clk); n++; end
  endtask

  localparam logic [127:0] K_A   = 128'h2b7e151628aed2a6abf7158809cf4f3c;
  localparam logic [127:0] K_A1  = 128'ha0fafe1788542cb123a339392a6c7605;
  localparam logic [127:0] K_A10 = 128'hd014f9a8c9ee2589e13f0cc8b6630ca6;
  localparam logic [127:0] K_B   = 128'h000102030405060708090a0b0c0d0e0f;
  localparam logic [127:0] K_B10 = 128'h13111d7fe3944a17f307a78b4d2b30c5;

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(round_idx == 0 && round_key == 0, "R1 reset key/index", round_key, '0);
    chk(key_valid == 1 && sbox_req == 0, "R1 reset valid/req", {key_valid, sbox_req}, 128'h2);

    cur_tag = "R2"; key_in = K_A; cmd(0);
    chk(round_key == K_A && round_idx == 0, "R2 load", round_key, K_A);

    cur_tag = "R3"; cmd(3); wait_idle(n);
    chk(n == 2, "R5 step length", n, 2);
    chk(round_key == K_A1, "R3 round key 1", round_key, K_A1);

    cur_tag = "R4"; cmd(4); wait_idle(n);
    chk(round_key == K_A, "R4 back to cipher key", round_key, K_A);

    cur_tag = "R7"; cmd(4); @(negedge clk);
    chk(round_idx == 0 && round_key == K_A && key_valid, "R7 backward at 0 ignored", round_key, K_A);

    cur_tag = "R8"; cmd(2); wait_idle(n);
    chk(n == 20, "R8 setup length", n, 20);
    chk(round_key == K_A10 && round_idx == 10, "R8 round key 10", round_key, K_A10);

    cur_tag = "R7"; cmd(3); @(negedge clk);
    chk(round_idx == 10 && round_key == K_A10 && key_valid, "R7 forward at 10 ignored", round_key, K_A10);
    cmd(2); @(negedge clk);
    chk(round_idx == 10 && key_valid, "R7 setup at 10 ignored", round_idx, 10);

    cur_tag = "R4";
    for (int i = 0; i < 10; i++) begin cmd(4); wait_idle(n); end
    chk(round_key == K_A && round_idx == 0, "R4 ten steps back", round_key, K_A);

    cur_tag = "R9"; cmd(2); wait_idle(n); cmd(1);
    chk(round_key == K_A && round_idx == 0 && key_valid, "R9 restore one cycle", round_key, K_A);
    cmd(3); wait_idle(n); cmd(3); wait_idle(n); cmd(1);
    chk(round_key == K_A && round_idx == 0, "R9 restore from round 2", round_key, K_A);

    cur_tag = "R5"; sb_lat = 3; cmd(3); wait_idle(n);
    chk(n == 5, "R5 slow S-box step length", n, 5);
    chk(round_key == K_A1, "R5 slow S-box key", round_key, K_A1);
    cmd(4); wait_idle(n); sb_lat = 0;

    cur_tag = "R10"; key_in = K_B;
    @(negedge clk); key_setup = 1;
    @(negedge clk); key_setup = 0; key_load = 1; step_bwd = 1;
    @(negedge clk); key_load = 0; step_bwd = 0;
    wait_idle(n);
    chk(round_key == K_A10 && round_idx == 10, "R10 commands ignored while busy", round_key, K_A10);
    @(negedge clk); key_load = 1; step_fwd = 1; key_setup = 1; key_restore = 1;
    @(negedge clk); key_load = 0; step_fwd = 0; key_setup = 0; key_restore = 0;
    chk(round_key == K_B && round_idx == 0, "R10 load has priority", round_key, K_B);
    @(negedge clk);
    chk(key_valid == 1 && round_idx == 0, "R10 no step after load", round_idx, 0);

    cur_tag = "R3";
    for (int i = 0; i < 10; i++) begin cmd(3); wait_idle(n); end
    chk(round_key == K_B10, "R3 second key round 10", round_key, K_B10);
    cur_tag = "R4"; cmd(4); wait_idle(n); cmd(3); wait_idle(n);
    chk(round_key == K_B10, "R4 back and forth", round_key, K_B10);

    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 60000 && !done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule